// File: doc/BRIEF.md
# Supply-Side Power-Good Status Responder

This block models the control-interface logic of a multi-output supply, as the host-side sequencer sees it. Each output module has one bidirectional line. In normal operation the responder reads each line level as that module's enable. A high level, which is also what an open line reads, turns the module on. A low level turns it off. A global shutdown input turns every module off in any mode.

A rising edge on the read-request input starts a status read. At that edge the responder captures a snapshot: a module reads good only if it was on and its health bit was set. It freezes the per-line enables. It waits a guard interval so the host can release the lines, then drives the snapshot onto the lines. After the full measurement interval it raises data valid.

When the request drops, the responder releases the lines and clears data valid on the next clock. It then goes back to sampling enables. A sticky contention flag records any clock on which both the host and the responder drive the same line. The bench uses this flag to judge the host's timing.

Top module: `pgr_responder`

## Requirements
- R1: Outside a read, every clock samples each line level as its enable (1 = on). `mod_on_o[n]` equals the sampled level ANDed with NOT `gsd_i`, one clock after the level is presented.
- R2: With `gsd_i` high at a clock edge, all `mod_on_o` bits are 0 after that edge, whether or not a read is in progress.
- R3: Only a 0-to-1 transition of `rd_req_i` starts a read. The status is captured at that edge as health AND (enable AND NOT `gsd_i`) AND presence mask. Holding the request high never refreshes it, even if health changes.
- R4: From the request edge until one clock after the request falls, level changes on the lines do not alter the held enables. `mod_on_o` stays equal to the frozen enables AND NOT `gsd_i`.
- R5: `line_oe_o` is 0 for the first `GUARD_CYC`-1 clocks after the edge clock. It becomes all ones exactly `GUARD_CYC` clocks after it, with `line_o` carrying the snapshot.
- R6: `data_valid_o` rises exactly `MEAS_CYC` clocks after the edge clock and stays high until the request falls.
- R7: Bit n of `line_o` reports module n. A line whose `PRESENT_MASK` bit is 0 is driven 0.
- R8: If `rd_req_i` is low at a clock edge, `line_oe_o` and `data_valid_o` are 0 after that edge. Enable sampling resumes on the following edge.
- R9: `contention_o` goes to 1 one clock after any edge where `line_oe_o[n]` and `host_drv_i[n]` are both 1. It stays 1 until reset.
- R10: During reset, `line_oe_o`, `line_o`, `data_valid_o`, `mod_on_o` and `contention_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_i | input | 1 | Status read request from the host |
| gsd_i | input | 1 | Global shutdown, active high |
| line_i | input | NUM_LINES | Observed level on each bidirectional line |
| host_drv_i | input | NUM_LINES | Host output-enable per line, used for contention checking |
| health_i | input | NUM_LINES | Per-module health, 1 = healthy |
| line_oe_o | output | NUM_LINES | Responder output-enable per line |
| line_o | output | NUM_LINES | Status value driven onto the lines |
| data_valid_o | output | 1 | Status on the lines is valid |
| mod_on_o | output | NUM_LINES | Power-on command per module |
| contention_o | output | 1 | Sticky flag for a both-sides-driving event |

## Verification
Two pairs of events can land on the same clock: a global shutdown with the request's rising edge, and a line change with that same edge. The bench provokes both on purpose. It raises `gsd_i` on the edge clock and expects an all-zero snapshot. It also scrambles the lines and health right after the edge and expects the frozen values to hold. It also drops the request before the guard interval ends while the host still drives the lines. There it expects no drive and no contention.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  typedef enum logic [0:0] {
    PGR_IDLE = 1'b0,
    PGR_READ = 1'b1
  } pgr_state_e;
endpackage

// File: rtl/pgr_enable_bank.sv
module pgr_enable_bank #(
  parameter int NUM_LINES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold_i,
  input  logic                 gsd_i,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] en_o,
  output logic [NUM_LINES-1:0] mod_on_o
);
  logic [NUM_LINES-1:0] en_q, en_d, mod_q, mod_d;
  logic                 en_ce;

  always_comb begin
    en_ce = ~hold_i;
    en_d  = en_ce ? line_i : en_q;
    mod_d = en_d & ~{NUM_LINES{gsd_i}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '1;
      mod_q <= '0;
    end else begin
      if (en_ce) en_q <= line_i;
      mod_q <= mod_d;
    end
  end

  assign en_o     = en_q;
  assign mod_on_o = mod_q;

  // R4
  frozen_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(en_q));
  // R2
  gsd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gsd_i |=> (mod_on_o == '0));
endmodule

// File: rtl/pgr_read_seq.sv
module pgr_read_seq
  import pgr_pkg::*;
#(
  parameter int GUARD_CYC = 300_000,
  parameter int MEAS_CYC  = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req_i,
  output logic rise_o,
  output logic busy_o,
  output logic drive_o,
  output logic valid_o
);
  localparam int CW = $clog2(MEAS_CYC + 1);
  localparam logic [CW-1:0] GUARD_W = CW'(GUARD_CYC);
  localparam logic [CW-1:0] MEAS_W  = CW'(MEAS_CYC);

  pgr_state_e      st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            req_q, drive_q, drive_d, valid_q, valid_d, rise;

  always_comb begin
    rise    = rd_req_i & ~req_q;
    st_d    = st_q;
    cnt_d   = cnt_q;
    drive_d = 1'b0;
    valid_d = 1'b0;
    case (st_q)
      PGR_IDLE: begin
        if (rise) begin
          st_d  = PGR_READ;
          cnt_d = '0;
        end
      end
      PGR_READ: begin
        if (!rd_req_i) begin
          st_d = PGR_IDLE;
        end else begin
          if (cnt_q != MEAS_W) cnt_d = cnt_q + 1'b1;
          drive_d = (cnt_d >= GUARD_W);
          valid_d = (cnt_d >= MEAS_W);
        end
      end
      default: st_d = PGR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PGR_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
      drive_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      req_q   <= rd_req_i;
      drive_q <= drive_d;
      valid_q <= valid_d;
    end
  end

  assign rise_o  = rise;
  assign busy_o  = (st_q == PGR_READ);
  assign drive_o = drive_q;
  assign valid_o = valid_q;

  // R6
  valid_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> drive_q);
  // R5
  guard_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_q) |-> (cnt_q == GUARD_W));
  // R6
  meas_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> (cnt_q == MEAS_W));
endmodule

// File: rtl/pgr_status_snap.sv
module pgr_status_snap #(
  parameter int                   NUM_LINES    = 3,
  parameter logic [NUM_LINES-1:0] PRESENT_MASK = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture_i,
  input  logic                 drive_i,
  input  logic [NUM_LINES-1:0] health_i,
  input  logic [NUM_LINES-1:0] on_i,
  output logic [NUM_LINES-1:0] line_o
);
  logic [NUM_LINES-1:0] snap_q, snap_d;

  always_comb begin
    snap_d = health_i & on_i & PRESENT_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else if (capture_i) snap_q <= snap_d;
  end

  assign line_o = drive_i ? snap_q : '0;

  // R3
  no_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(snap_q));
  // R7
  absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_o & ~PRESENT_MASK) == '0);
endmodule

// File: rtl/pgr_contention_mon.sv
module pgr_contention_mon #(
  parameter int NUM_LINES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] dev_oe_i,
  input  logic [NUM_LINES-1:0] host_oe_i,
  output logic                 flag_o
);
  logic [NUM_LINES-1:0] clash;
  logic                 flag_q, flag_d;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_clash
    assign clash[g] = dev_oe_i[g] & host_oe_i[g];
  end

  always_comb flag_d = flag_q | (|clash);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q);
endmodule

// File: rtl/pgr_responder.sv
module pgr_responder #(
  parameter int                   NUM_LINES    = 3,
  parameter int                   GUARD_CYC    = 300_000,
  parameter int                   MEAS_CYC     = 20_000_000,
  parameter logic [NUM_LINES-1:0] PRESENT_MASK = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_req_i,
  input  logic                 gsd_i,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [NUM_LINES-1:0] host_drv_i,
  input  logic [NUM_LINES-1:0] health_i,
  output logic [NUM_LINES-1:0] line_oe_o,
  output logic [NUM_LINES-1:0] line_o,
  output logic                 data_valid_o,
  output logic [NUM_LINES-1:0] mod_on_o,
  output logic                 contention_o
);
  logic                 rise, busy, drive, valid, hold;
  logic [NUM_LINES-1:0] en_w, on_at_edge;

  pgr_read_seq #(.GUARD_CYC(GUARD_CYC), .MEAS_CYC(MEAS_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req_i),
    .rise_o(rise), .busy_o(busy), .drive_o(drive), .valid_o(valid)
  );

  assign hold       = rise | busy;
  assign on_at_edge = en_w & ~{NUM_LINES{gsd_i}};

  pgr_enable_bank #(.NUM_LINES(NUM_LINES)) u_en (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .gsd_i(gsd_i),
    .line_i(line_i), .en_o(en_w), .mod_on_o(mod_on_o)
  );

  pgr_status_snap #(.NUM_LINES(NUM_LINES), .PRESENT_MASK(PRESENT_MASK)) u_snap (
    .clk(clk), .rst_n(rst_n), .capture_i(rise), .drive_i(drive),
    .health_i(health_i), .on_i(on_at_edge), .line_o(line_o)
  );

  assign line_oe_o    = {NUM_LINES{drive}};
  assign data_valid_o = valid;

  pgr_contention_mon #(.NUM_LINES(NUM_LINES)) u_mon (
    .clk(clk), .rst_n(rst_n), .dev_oe_i(line_oe_o), .host_oe_i(host_drv_i),
    .flag_o(contention_o)
  );

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> (line_oe_o == '0 && !data_valid_o));
  // R3
  disabled_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe_o != '0) |-> ((line_o & ~en_w) == '0));
  // R5
  drive_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe_o != '0 && $past(line_oe_o) != '0) |-> $stable(line_o));
endmodule

// File: tb/tb_pgr_responder.sv
module tb_pgr_responder;
  localparam int N     = 3;
  localparam int GUARD = 6;
  localparam int MEAS  = 15;
  localparam logic [N-1:0] MASK = 3'b011;

  logic clk = 1'b0;
  logic rst_n, rd_req_i, gsd_i;
  logic [N-1:0] line_i, host_drv_i, health_i;
  logic [N-1:0] line_oe_o, line_o, mod_on_o;
  logic data_valid_o, contention_o;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  pgr_responder #(.NUM_LINES(N), .GUARD_CYC(GUARD), .MEAS_CYC(MEAS),
                  .PRESENT_MASK(MASK)) dut (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req_i), .gsd_i(gsd_i),
    .line_i(line_i), .host_drv_i(host_drv_i), .health_i(health_i),
    .line_oe_o(line_oe_o), .line_o(line_o), .data_valid_o(data_valid_o),
    .mod_on_o(mod_on_o), .contention_o(contention_o)
  );

  function automatic logic [N-1:0] exp_status(logic [N-1:0] h, logic [N-1:0] en, logic g);
    return g ? '0 : (h & en & MASK);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic do_read(input logic [N-1:0] en_pat, input logic [N-1:0] h, input logic g);
    logic [N-1:0] exp, nxt;
    line_i = en_pat; gsd_i = 1'b0; tick();
    gsd_i = g; health_i = h; rd_req_i = 1'b1; tick();          // edge clock
    exp = exp_status(h, en_pat, g);
    gsd_i = 1'b0; health_i = ~h; line_i = N'($urandom);
    repeat (GUARD - 1) tick();
    check("R5 no drive before guard", 32'(line_oe_o), 0);
    tick();
    check("R5 drive at guard", 32'(line_oe_o), 32'({N{1'b1}}));
    check("R3/R7 snapshot", 32'(line_o), 32'(exp));
    check("R6 valid low at guard", 32'(data_valid_o), 0);
    line_i = N'($urandom); tick();
    check("R4 frozen enables", 32'(mod_on_o), 32'(en_pat));
    repeat (MEAS - GUARD - 2) tick();
    check("R6 valid low before delay", 32'(data_valid_o), 0);
    tick();
    check("R6 valid at delay", 32'(data_valid_o), 1);
    gsd_i = 1'b1; tick();
    check("R2 shutdown during read", 32'(mod_on_o), 0);
    gsd_i = 1'b0; tick();
    check("R4 enables restored after shutdown", 32'(mod_on_o), 32'(en_pat));
    health_i = N'($urandom); repeat (3) tick();
    check("R3 no refresh while high", 32'(line_o), 32'(exp));
    check("R6 valid held", 32'(data_valid_o), 1);
    nxt = N'($urandom);
    rd_req_i = 1'b0; line_i = nxt; tick();
    check("R8 release oe", 32'(line_oe_o), 0);
    check("R8 release valid", 32'(data_valid_o), 0);
    tick();
    check("R8/R1 sampling resumed", 32'(mod_on_o), 32'(nxt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240917));
    rst_n = 1'b0; rd_req_i = 1'b0; gsd_i = 1'b0;
    line_i = '1; host_drv_i = '0; health_i = '0;
    repeat (3) tick();
    check("R10 oe in reset", 32'(line_oe_o), 0);
    check("R10 line_o in reset", 32'(line_o), 0);
    check("R10 valid in reset", 32'(data_valid_o), 0);
    check("R10 mod_on in reset", 32'(mod_on_o), 0);
    check("R10 contention in reset", 32'(contention_o), 0);
    rst_n = 1'b1; tick();

    for (int i = 0; i < 12; i++) begin
      logic [N-1:0] l; logic g;
      l = N'($urandom); g = ($urandom % 4) == 0;
      line_i = l; gsd_i = g; tick();
      if (g) check("R2 shutdown in normal mode", 32'(mod_on_o), 0);
      else   check("R1 enable sampling", 32'(mod_on_o), 32'(l));
    end
    gsd_i = 1'b0;

    do_read(3'b111, 3'b111, 1'b0);   // all enabled and healthy
    do_read(3'b000, 3'b111, 1'b0);   // disabled modules read 0
    do_read(3'b111, 3'b111, 1'b1);   // shutdown on the edge clock
    do_read(3'b101, 3'b110, 1'b0);
    for (int i = 0; i < 6; i++) begin
      logic [N-1:0] e, h;
      e = N'($urandom); h = N'($urandom);
      do_read(e, h, ($urandom % 4) == 0);
    end

    // early fall with host still driving: no drive, no contention
    line_i = '1; tick();
    host_drv_i = '1; rd_req_i = 1'b1; tick();
    repeat (2) tick();
    rd_req_i = 1'b0; tick();
    repeat (GUARD + 2) tick();
    check("R8 early fall never drives", 32'(line_oe_o), 0);
    check("R9 no contention without drive", 32'(contention_o), 0);
    host_drv_i = '0;

    // contention
    rd_req_i = 1'b1; tick();
    repeat (GUARD) tick();
    check("R5 drive before contention test", 32'(line_oe_o), 32'({N{1'b1}}));
    host_drv_i = 3'b001; tick();
    check("R9 contention set", 32'(contention_o), 1);
    host_drv_i = '0; rd_req_i = 1'b0; repeat (3) tick();
    check("R9 contention sticky", 32'(contention_o), 1);

    finish_run();
  end
endmodule